// File: doc/BRIEF.md
# Write-Protected Converter Control Register Bank

This block is the control register bank of a five-port media converter that sits between Ethernet MACs and external PHYs. A simple synchronous register bus reaches it through an address, a write strobe with data, and a read strobe with data. The block holds these values and drives them straight out as plain control outputs:

- the switch mode selection,
- one control word per converter port,
- the per-port reset-release bits,
- the switch speed and duplex override masks.

The data path conversion itself lives elsewhere.

All configuration registers are write-protected. A write to one of them takes effect only after four specific words have been written, in order, to a command register. Such an unlock grants exactly one protected write, and the bank then locks again. A protected write made while the bank is locked is dropped and raises a sticky error flag, which software can read back at the command address.

Top module: `conv_ctrl_regs`

## Requirements
- R1: After reset the following are all zero: every output, the mode, every control word, every release bit and both override masks. The bank starts locked, so the command address reads 0.
- R2: Writing 0x000000A5, 0x00000001, 0x0000FFFE and 0x00000001 to address 0x000, in that order, unlocks the bank. While it is unlocked, bit 1 of the command register reads 1.
- R3: A command write that does not match the next expected word restarts the sequence check. If that mismatching word is 0x000000A5, it counts as the first step of a new attempt.
- R4: After an unlock, exactly one write to a protected register takes effect, and the bank then locks again. A second protected write is ignored.
- R5: A protected write while locked leaves every register unchanged. It sets bit 0 of the command register, and that bit stays set until reset.
- R6: The mode register at 0x020 keeps bits [4:0] and drives `sw_mode_o`. Its other bits read 0.
- R7: Port p (0 to 4) has a control word at 0x100 + 4·p. Only these bits are kept (mask 0xF10F): [1:0] speed code (0 = 10, 1 = 100, 2 = 1000 Mb/s), [3:2] interface code (0 = MII, 1 = RMII, 2 = RGMII), 8 full duplex, 12 RGMII link, 13 RGMII duplex, [15:14] RGMII speed. Port p appears on `conv_ctrl_o[16p+15:16p]`.
- R8: Address 0x114 holds the release bits [4:0]. A 1 in bit n releases converter n from reset, and a 0 holds it in reset. The register drives `conv_rel_o`.
- R9: The speed override mask at 0x304 and the duplex override mask at 0x308 each keep bits [4:0] and drive `sw_spd_ovr_o` and `sw_dup_ovr_o`. Writing zero returns control to the switch.
- R10: Address 0x004 reads the constant `ID_CODE`, and unmapped addresses read 0. Writes to either change no register and do not consume an unlock.
- R11: `rd_data` is 0 whenever `rd_en` is low, and otherwise shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational |
| sw_mode_o | output | 5 | Switch mode selection |
| conv_ctrl_o | output | 80 | Five 16-bit converter control words |
| conv_rel_o | output | 5 | Per-port converter reset release |
| sw_spd_ovr_o | output | 5 | Switch speed override mask |
| sw_dup_ovr_o | output | 5 | Switch duplex override mask |

## Verification
The bench attacks the unlock sequence with three patterns:

- a correct sequence,
- a sequence broken by a wrong fourth word, which must leave the bank locked,
- a sequence that restarts on an interleaved 0xA5, which must still unlock.

A design that resets to step zero on every mismatch would fail the last pattern. A design that never relocks, or that lets a locked write through, would show changed outputs after the second write. Address decode is checked against the masked readback of each control word and against the per-port output slices, so a wrong stride or a wrong bit mask shows up as a wrong value. Writes to the identification register and to unmapped addresses are checked not to consume a pending unlock.

// File: rtl/conv_ctrl_regs.sv
module conv_ctrl_regs #(
  parameter int              NPORTS    = 5,
  parameter int              AW        = 12,
  parameter int              DW        = 32,
  parameter int              CW        = 16,
  parameter logic [DW-1:0]   ID_CODE   = 32'h0000_4D43,
  parameter logic [CW-1:0]   CTRL_MASK = 16'hF10F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_en,
  output logic [DW-1:0]        rd_data,
  output logic [4:0]           sw_mode_o,
  output logic [NPORTS*CW-1:0] conv_ctrl_o,
  output logic [NPORTS-1:0]    conv_rel_o,
  output logic [NPORTS-1:0]    sw_spd_ovr_o,
  output logic [NPORTS-1:0]    sw_dup_ovr_o
);

  localparam logic [AW-1:0] A_CMD  = AW'(12'h000);
  localparam logic [AW-1:0] A_ID   = AW'(12'h004);
  localparam logic [AW-1:0] A_MODE = AW'(12'h020);
  localparam logic [AW-1:0] A_CTRL = AW'(12'h100);
  localparam logic [AW-1:0] A_REL  = AW'(12'h114);
  localparam logic [AW-1:0] A_SPD  = AW'(12'h304);
  localparam logic [AW-1:0] A_DUP  = AW'(12'h308);
  localparam logic [DW-1:0] K0 = DW'(32'h0000_00A5);
  localparam logic [DW-1:0] K1 = DW'(32'h0000_0001);
  localparam logic [DW-1:0] K2 = DW'(32'h0000_FFFE);

  logic [1:0]        step_q;
  logic              unlocked_q, err_q;
  logic [4:0]        mode_q;
  logic [NPORTS-1:0] rel_q, spd_q, dup_q;
  logic [CW-1:0]     ctrl_q [NPORTS];
  logic [NPORTS-1:0] ctrl_hit;
  logic [DW-1:0]     exp_word, ctrl_rd;

  wire cmd_hit  = (addr == A_CMD);
  wire mode_hit = (addr == A_MODE);
  wire rel_hit  = (addr == A_REL);
  wire spd_hit  = (addr == A_SPD);
  wire dup_hit  = (addr == A_DUP);
  wire prot_hit = mode_hit | rel_hit | spd_hit | dup_hit | (|ctrl_hit);
  wire commit   = wr_en & unlocked_q;

  always_comb begin
    case (step_q)
      2'd0:    exp_word = K0;
      2'd2:    exp_word = K2;
      default: exp_word = K1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q     <= 2'd0;
      unlocked_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (wr_en && cmd_hit) begin
        if (wr_data == exp_word) begin
          if (step_q == 2'd3) begin
            unlocked_q <= 1'b1;
            step_q     <= 2'd0;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end else begin
          step_q <= (wr_data == K0) ? 2'd1 : 2'd0;
        end
      end
      if (wr_en && prot_hit) begin
        if (unlocked_q) unlocked_q <= 1'b0;
        else            err_q      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      rel_q  <= '0;
      spd_q  <= '0;
      dup_q  <= '0;
    end else if (commit) begin
      if (mode_hit) mode_q <= wr_data[4:0];
      if (rel_hit)  rel_q  <= wr_data[NPORTS-1:0];
      if (spd_hit)  spd_q  <= wr_data[NPORTS-1:0];
      if (dup_hit)  dup_q  <= wr_data[NPORTS-1:0];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign ctrl_hit[p] = (addr == A_CTRL + AW'(4 * p));
    always_ff @(posedge clk) begin
      if (!rst_n)                   ctrl_q[p] <= '0;
      else if (commit && ctrl_hit[p]) ctrl_q[p] <= wr_data[CW-1:0] & CTRL_MASK;
    end
    assign conv_ctrl_o[p*CW +: CW] = ctrl_q[p];
  end

  always_comb begin
    ctrl_rd = '0;
    for (int p = 0; p < NPORTS; p++)
      if (ctrl_hit[p]) ctrl_rd = DW'(ctrl_q[p]);
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if      (cmd_hit)      rd_data = DW'({unlocked_q, err_q});
      else if (addr == A_ID) rd_data = ID_CODE;
      else if (mode_hit)     rd_data = DW'(mode_q);
      else if (rel_hit)      rd_data = DW'(rel_q);
      else if (spd_hit)      rd_data = DW'(spd_q);
      else if (dup_hit)      rd_data = DW'(dup_q);
      else                   rd_data = ctrl_rd;
    end
  end

  assign sw_mode_o    = mode_q;
  assign conv_rel_o   = rel_q;
  assign sw_spd_ovr_o = spd_q;
  assign sw_dup_ovr_o = dup_q;

  // R2
  unlock_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(wr_en && cmd_hit && wr_data == K1));
  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_hit && unlocked_q) |=> !unlocked_q);
  // R5
  locked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_hit && !unlocked_q) |=> (err_q && $stable(sw_mode_o) && $stable(conv_rel_o) && $stable(conv_ctrl_o)));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R8
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rel_hit) |=> $stable(conv_rel_o));
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

endmodule

// File: tb/conv_ctrl_regs_tb.sv
module conv_ctrl_regs_tb_top;
  localparam logic [31:0] ID = 32'h0000_4D43;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [4:0]  sw_mode_o, conv_rel_o, sw_spd_ovr_o, sw_dup_ovr_o;
  logic [79:0] conv_ctrl_o;
  int total = 0, bad = 0;
  bit done = 0;

  conv_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sw_mode_o(sw_mode_o),
    .conv_ctrl_o(conv_ctrl_o), .conv_rel_o(conv_rel_o),
    .sw_spd_ovr_o(sw_spd_ovr_o), .sw_dup_ovr_o(sw_dup_ovr_o));

  always #10 clk = ~clk;

  // {addr, write data, expected readback}
  localparam int NV = 10;
  localparam logic [75:0] VEC [NV] = '{
    {12'h020, 32'hFFFF_FFFF, 32'h0000_001F},
    {12'h020, 32'h0000_000A, 32'h0000_000A},
    {12'h100, 32'hFFFF_FFFF, 32'h0000_F10F},
    {12'h104, 32'h0000_1234, 32'h0000_1004},
    {12'h108, 32'h0000_A106, 32'h0000_A106},
    {12'h10C, 32'h0000_C109, 32'h0000_C109},
    {12'h110, 32'h0000_5102, 32'h0000_5102},
    {12'h114, 32'hFFFF_FFFF, 32'h0000_001F},
    {12'h304, 32'h0000_FFFF, 32'h0000_001F},
    {12'h308, 32'h0000_0015, 32'h0000_0015}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rd_data;
    rd_en = 0;
  endtask

  task automatic unlock();
    wr(12'h000, 32'hA5); wr(12'h000, 32'h1); wr(12'h000, 32'hFFFE); wr(12'h000, 32'h1);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 outputs", {sw_mode_o, conv_rel_o, sw_spd_ovr_o, sw_dup_ovr_o, 12'h0}, 32'h0);
    chk("R1 ctrl", 32'(|conv_ctrl_o), 32'h0);
    rd(12'h000, v); chk("R1 cmd", v, 32'h0);
    // R10
    rd(12'h004, v); chk("R10 id", v, ID);
    rd(12'h200, v); chk("R10 unmapped", v, 32'h0);
    // R11
    @(negedge clk); addr = 12'h004; rd_en = 0; #1 chk("R11 idle", rd_data, 32'h0);

    // R6 R7 R8 R9 via table
    for (int i = 0; i < NV; i++) begin
      unlock();
      rd(12'h000, v); chk("R2 unlocked", v, 32'h2);
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], v); chk("R6-9 table readback", v, VEC[i][31:0]);
    end
    chk("R7 port0", 32'(conv_ctrl_o[15:0]),  32'hF10F);
    chk("R7 port1", 32'(conv_ctrl_o[31:16]), 32'h1004);
    chk("R7 port4", 32'(conv_ctrl_o[79:64]), 32'h5102);
    chk("R6 mode out", 32'(sw_mode_o), 32'hA);
    chk("R8 release out", 32'(conv_rel_o), 32'h1F);
    chk("R9 override out", 32'({sw_spd_ovr_o, sw_dup_ovr_o}), 32'h3F5);
    rd(12'h000, v); chk("R4 relocked", v, 32'h0);

    // R4 second write ignored
    unlock();
    wr(12'h020, 32'h3);
    wr(12'h020, 32'h7);
    chk("R4 second write", 32'(sw_mode_o), 32'h3);
    rd(12'h000, v); chk("R5 err after locked write", v, 32'h1);

    // R5 locked write to release ignored, err sticky
    wr(12'h114, 32'h0);
    chk("R5 locked ignored", 32'(conv_rel_o), 32'h1F);
    rd(12'h000, v); chk("R5 err sticky", v, 32'h1);

    // R3 wrong last word leaves locked
    wr(12'h000, 32'hA5); wr(12'h000, 32'h1); wr(12'h000, 32'hFFFE); wr(12'h000, 32'h2);
    rd(12'h000, v); chk("R3 bad order locked", v, 32'h1);
    // R3 A5 restart counts as step one
    wr(12'h000, 32'hA5); wr(12'h000, 32'h1); wr(12'h000, 32'hA5);
    wr(12'h000, 32'h1); wr(12'h000, 32'hFFFE); wr(12'h000, 32'h1);
    rd(12'h000, v); chk("R3 A5 restart unlocks", v, 32'h3);
    // R10 writes to id and unmapped do not consume unlock
    wr(12'h004, 32'h0); wr(12'h200, 32'h5);
    rd(12'h004, v); chk("R10 id const", v, ID);
    rd(12'h000, v); chk("R10 unlock kept", v, 32'h3);
    // R8 hold port 2 in reset
    wr(12'h114, 32'h1B);
    chk("R8 port2 held", 32'(conv_rel_o), 32'h1B);
    rd(12'h000, v); chk("R4 relock after release write", v, 32'h1);
    // R9 zero returns control
    unlock(); wr(12'h304, 32'h0);
    chk("R9 speed override cleared", 32'(sw_spd_ovr_o), 32'h0);

    // R1 reset again
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 reset clears", {sw_mode_o, conv_rel_o, sw_spd_ovr_o, sw_dup_ovr_o, 12'h0}, 32'h0);
    rd(12'h000, v); chk("R1 reset cmd", v, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule